// File: doc/BRIEF.md
# Programmable Timing Output Channel Bank

A bank of independently programmed timing and sync outputs. Each channel owns a small control register on a simple parallel register bus (address, strobe, direction, data). The register chooses where the channel's level comes from: a data bit held in the register itself, a per-channel external level input, or one bit of a pattern word that an upstream sequencer supplies every clock. The chosen level reaches the output pin only while the channel is enabled. A channel is enabled when its register enable bit is set or when its external enable input is high.

Software writes a register by raising the strobe with the direction set to write. On a read, the block returns the stored control bits together with a read-only snapshot. The snapshot is the level the channel's output had at the clock edge of the last write to that register. All channel outputs and the read data are registered on the system clock, and every register clears on a synchronous active-high reset.

Top module: `timing_out_bank`

## Requirements
- R1: Reset clears every control register and every snapshot, drives every channel output low, and drives the read data to zero.
- R2: A write happens only on the clock where the strobe is high after being low and the direction input is 1 (write). The address selects the channel with the same index, 0 to NUM_CH-1. Keeping the strobe high does not write again. A write to an address at or above NUM_CH, or a strobe with the direction at 0, changes no register.
- R3: When none of the three source-select bits (bits 0, 1, 2) is set, the channel output is low whatever the enables are.
- R4: With bit 0 (register source) as the only select, the output equals register bit 4 AND (register bit 3 OR the channel's external enable).
- R5: With bit 1 (external source) as the highest select set, the output equals the channel's external level input AND (bit 3 OR external enable).
- R6: With bit 2 (pattern source) set, the output equals the channel's bit of the pattern word AND (bit 3 OR external enable).
- R7: When several select bits are set, the pattern source wins over the external source, and the external source wins over the register source.
- R8: A write copies the channel output level present at that write's clock edge, which is the level before the new setting takes effect, into the snapshot that reads back as bit 5.
- R9: The read data is {2'b00, snapshot, stored bits 4:0} of the addressed channel. It is registered, so it shows the address of the previous clock. Written bits 7:5 are not stored. An address at or above NUM_CH reads as zero.
- R10: A channel output follows its inputs and its control register with exactly one clock of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address, one register per channel |
| bus_stb | input | 1 | Access strobe; a write takes effect on its rising edge |
| bus_wr | input | 1 | Direction: 1 = write, 0 = read |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| ext_bit | input | NUM_CH | Per-channel external level source |
| ext_en | input | NUM_CH | Per-channel external enable |
| pattern | input | NUM_CH | Pattern word from the sequencer, one bit per channel |
| chan_out | output | NUM_CH | Registered channel outputs |

## Verification
A corrupted control register shows up on its channel's output one clock later, unless the channel is disabled or its selected source happens to be low. A readback of that channel shows the corruption one clock after its address is presented. A snapshot captured on the wrong edge can only be seen by reading the register back after a write, so the bench writes channels whose outputs are high and reads them back at once. A false or repeated write strobe changes the readback of an unrelated channel. The reference model compares every output and the read data on every clock, so the first wrong value is reported in the cycle it appears.

// File: rtl/tob_pkg.sv
package tob_pkg;
  // Stored control field, bits 4:0 of each channel register
  localparam int CFG_W    = 5;
  localparam int SNAP_POS = 5;

  typedef struct packed {
    logic data;     // bit 4: level used by the register source
    logic en;       // bit 3: register output enable
    logic sel_pat;  // bit 2: pattern word source
    logic sel_ext;  // bit 1: external level source
    logic sel_reg;  // bit 0: register data source
  } cfg_t;
endpackage

// File: rtl/tob_bus_front.sv
module tob_bus_front #(
  parameter int NUM_CH = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_stb,
  input  logic              bus_wr,
  output logic [NUM_CH-1:0] wr_sel
);
  logic stb_q;
  logic wr_pulse;

  always_ff @(posedge clk) begin
    if (rst) stb_q <= 1'b0;
    else     stb_q <= bus_stb;
  end

  assign wr_pulse = bus_stb & ~stb_q & bus_wr;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    assign wr_sel[g] = wr_pulse && (32'(bus_addr) == g);
  end

  // R2: one write per strobe; a write is never followed by another on the next clock
  p_single_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_sel != '0) |=> (wr_sel == '0));
endmodule

// File: rtl/tob_channel.sv
module tob_channel
  import tob_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  input  logic             ext_bit,
  input  logic             ext_en,
  input  logic             pat_bit,
  output logic             out_q,
  output cfg_t             cfg_q,
  output logic             snap_q
);
  logic src;
  logic gate;

  // Priority: pattern, then external level, then register data
  always_comb begin
    if (cfg_q.sel_pat)      src = pat_bit;
    else if (cfg_q.sel_ext) src = ext_bit;
    else if (cfg_q.sel_reg) src = cfg_q.data;
    else                    src = 1'b0;
  end

  assign gate = cfg_q.en | ext_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      snap_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      out_q <= src & gate;
      if (we) begin
        cfg_q  <= cfg_t'(wdata);
        snap_q <= out_q;
      end
    end
  end

  p_nosrc_low_r3: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q.sel_pat && !cfg_q.sel_ext && !cfg_q.sel_reg) |=> !out_q);

  p_gated_off_r4: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q.en && !ext_en) |=> !out_q);

  p_pattern_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.sel_pat && (cfg_q.en || ext_en)) |=> (out_q == $past(pat_bit)));

  p_hold_cfg_r2: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(cfg_q));

  p_snapshot_r8: assert property (@(posedge clk) disable iff (rst)
    we |=> (snap_q == $past(out_q)));
endmodule

// File: rtl/timing_out_bank.sv
module timing_out_bank
  import tob_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_stb,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] ext_bit,
  input  logic [NUM_CH-1:0] ext_en,
  input  logic [NUM_CH-1:0] pattern,
  output logic [NUM_CH-1:0] chan_out
);
  localparam int IDX_W  = $clog2(NUM_CH);
  localparam int VIEW_W = CFG_W + 1;

  logic [NUM_CH-1:0] wr_sel;
  logic [VIEW_W-1:0] view [NUM_CH];
  logic              in_range;
  logic [IDX_W-1:0]  idx;
  logic              unused_wbits;

  assign unused_wbits = ^bus_wdata[DATA_W-1:CFG_W];

  tob_bus_front #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_front (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_stb  (bus_stb),
    .bus_wr   (bus_wr),
    .wr_sel   (wr_sel)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    cfg_t cfg;
    logic snap;

    tob_channel i_ch (
      .clk     (clk),
      .rst     (rst),
      .we      (wr_sel[g]),
      .wdata   (bus_wdata[CFG_W-1:0]),
      .ext_bit (ext_bit[g]),
      .ext_en  (ext_en[g]),
      .pat_bit (pattern[g]),
      .out_q   (chan_out[g]),
      .cfg_q   (cfg),
      .snap_q  (snap)
    );

    assign view[g] = {snap, cfg};
  end

  assign in_range = 32'(bus_addr) < NUM_CH;
  assign idx      = bus_addr[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)           bus_rdata <= '0;
    else if (in_range) bus_rdata <= DATA_W'(view[idx]);
    else               bus_rdata <= '0;
  end

  p_rd_out_of_range_r9: assert property (@(posedge clk) disable iff (rst)
    !in_range |=> (bus_rdata == '0));

  p_rd_upper_zero_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (bus_rdata[DATA_W-1:SNAP_POS+1] == '0));
endmodule

// File: tb/test_timing_out_bank.sv
`timescale 1ns/1ps
module test_timing_out_bank;
  localparam int NCH = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_stb = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [NCH-1:0] ext_bit = '0, ext_en = '0, pattern = '0;
  logic [NCH-1:0] chan_out;

  int checks = 0;
  int fails  = 0;
  bit started = 0;

  always #4 clk = ~clk;

  timing_out_bank i_timing_out_bank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_stb(bus_stb),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_bit(ext_bit), .ext_en(ext_en), .pattern(pattern), .chan_out(chan_out)
  );

  // ---------------- reference model ----------------
  logic [4:0] mctrl [NCH];
  bit         msnap [NCH];
  logic [NCH-1:0] mout;
  logic [7:0] mrd;
  bit         mstbq;

  function automatic bit mfunc(int i);
    bit s;
    if (mctrl[i][2])      s = pattern[i];
    else if (mctrl[i][1]) s = ext_bit[i];
    else if (mctrl[i][0]) s = mctrl[i][4];
    else                  s = 1'b0;
    return s & (mctrl[i][3] | ext_en[i]);
  endfunction

  always @(posedge clk) begin
    logic [NCH-1:0] nout;
    logic [7:0] nrd;
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin mctrl[i] = '0; msnap[i] = 0; end
      mout = '0; mrd = '0; mstbq = 0;
    end else begin
      for (int i = 0; i < NCH; i++) nout[i] = mfunc(i);
      nrd = (int'(bus_addr) < NCH) ? {2'b00, msnap[bus_addr], mctrl[bus_addr]} : 8'h00;
      if (bus_stb && !mstbq && bus_wr && int'(bus_addr) < NCH) begin
        msnap[bus_addr] = mout[bus_addr];
        mctrl[bus_addr] = bus_wdata[4:0];
      end
      mout = nout; mrd = nrd; mstbq = bus_stb;
    end
    started = 1;
  end

  // Every-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (chan_out !== mout) begin
        fails++;
        $display("FAIL R1/R3/R4/R5/R6/R7/R10 chan_out actual=%h expected=%h", chan_out, mout);
      end
      checks++;
      if (bus_rdata !== mrd) begin
        fails++;
        $display("FAIL R1/R2/R8/R9 bus_rdata actual=%h expected=%h", bus_rdata, mrd);
      end
    end
  end

  // ---------------- directed checks ----------------
  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    bus_addr = 8'(a); bus_wdata = d; bus_wr = 1'b1; bus_stb = 1'b1;
    @(negedge clk); bus_stb = 1'b0; bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(int a, output logic [7:0] d);
    bus_addr = 8'(a); bus_wr = 1'b0;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 outputs after reset", 8'(chan_out != 0), 8'h00);
    rd(0, d);  chk("R1 readback ch0 after reset", d, 8'h00);
    rd(31, d); chk("R1 readback ch31 after reset", d, 8'h00);

    // R3: enable and data set, no source
    ext_en[3] = 1'b1;
    wr(3, 8'h18); chk("R3 no source stays low", 8'(chan_out[3]), 8'h00);

    // R4: register source
    wr(0, 8'h19); chk("R4/R10 reg source enabled", 8'(chan_out[0]), 8'h01);
    wr(1, 8'h11); chk("R4 reg source not enabled", 8'(chan_out[1]), 8'h00);
    ext_en[1] = 1'b1; step();
    chk("R4 ext enable gates reg source", 8'(chan_out[1]), 8'h01);

    // R5: external source
    wr(5, 8'h0A); chk("R5 ext level low", 8'(chan_out[5]), 8'h00);
    ext_bit[5] = 1'b1; step();
    chk("R5/R10 ext level high", 8'(chan_out[5]), 8'h01);

    // R6: pattern source enabled by external enable only
    ext_en[31] = 1'b1;
    wr(31, 8'h04);
    pattern[31] = 1'b1; step(); chk("R6 pattern one", 8'(chan_out[31]), 8'h01);
    pattern[31] = 1'b0; step(); chk("R6 pattern zero", 8'(chan_out[31]), 8'h00);
    ext_en[31] = 1'b0; pattern[31] = 1'b1; step();
    chk("R6 pattern without enable", 8'(chan_out[31]), 8'h00);

    // R7: priority
    ext_bit[7] = 1'b1; pattern[7] = 1'b0;
    wr(7, 8'h1F); chk("R7 pattern beats ext", 8'(chan_out[7]), 8'h00);
    pattern[7] = 1'b1; step(); chk("R7 pattern selected", 8'(chan_out[7]), 8'h01);
    ext_bit[8] = 1'b0;
    wr(8, 8'h1B); chk("R7 ext beats reg", 8'(chan_out[8]), 8'h00);

    // R8: snapshot of level at the write
    wr(0, 8'h08); rd(0, d); chk("R8 snapshot high", d, 8'h28);
    chk("R8 new setting applied", 8'(chan_out[0]), 8'h00);
    wr(0, 8'h08); rd(0, d); chk("R8 snapshot low", d, 8'h08);

    // R9: upper bits dropped, out of range reads zero
    wr(9, 8'hFF); rd(9, d); chk("R9 upper bits not stored", d, 8'h1F);
    rd(40, d);  chk("R9 out of range read", d, 8'h00);
    rd(200, d); chk("R9 high address read", d, 8'h00);

    // R2: out-of-range write must not alias onto ch8
    wr(40, 8'h19); rd(8, d); chk("R2 out of range write ignored", d, 8'h1B);
    chk("R2 ch8 output unchanged", 8'(chan_out[8]), 8'h00);
    // R2: held strobe writes once
    bus_addr = 8'd12; bus_wdata = 8'h19; bus_wr = 1'b1; bus_stb = 1'b1;
    @(negedge clk); bus_wdata = 8'h11;
    @(negedge clk); bus_stb = 1'b0; bus_wr = 1'b0;
    rd(12, d); chk("R2 held strobe single write", d, 8'h19);
    // R2: read direction does not write
    bus_addr = 8'd13; bus_wdata = 8'h19; bus_wr = 1'b0; bus_stb = 1'b1;
    @(negedge clk); bus_stb = 1'b0;
    rd(13, d); chk("R2 read strobe no write", d, 8'h00);

    // R10: mixed input activity against the per-clock model
    for (int k = 0; k < 64; k++) begin
      pattern = {pattern[NCH-2:0], pattern[NCH-1] ^ pattern[3]} ^ NCH'(k);
      ext_bit = ~ext_bit ^ NCH'(k * 7);
      ext_en  = ext_en ^ NCH'(32'h1 << (k % NCH));
      step();
    end

    // R1: reset again in mid run
    rst = 1'b1; step(); rst = 1'b0;
    chk("R1 outputs after second reset", 8'(chan_out != 0), 8'h00);
    rd(9, d); chk("R1 register cleared", d, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule